// File: doc/BRIEF.md
# State Word Dispatch Queue

This block moves opaque processor state words between a group of identical arithmetic processors and one I/O return port. When a processor forks, it keeps one of the two resulting state words and offers the other to the block. When a processor reaches a join that is not the last one, it halts and raises a wait line until it is handed a new state word. The block keeps the offered words in one shared first-in first-out store. It gives the oldest stored word to a halted processor in the first cycle where both a word and a halted processor exist. Processors have no identity of their own: whichever processor is idle takes the next pending path.

The I/O port returns a finished operation's state word in one of two ways. It can place the word in the shared store, or it can hand the word straight to a halted processor. The block also reports how many processors are running. A final join keeps its own state word, so it never reaches this block. Fork and join counters, main memory and the meaning of the state word are outside its scope. The only field the block exposes is the program number, which sits in the top bits of the word.

Top module: `swd_dispatch`

## Requirements
- R1: After reset no grant is raised, the store is empty, `fork_ready` is all zero while no fork word is offered, and `active_cnt` equals the number of processors with `wait_req` low.
- R2: Words taken into the store are delivered in the order they were accepted, oldest first.
- R3: The store may hold words while a processor is eligible. An eligible processor is one with `wait_req` high and no grant pending for it. In that case a grant is decided in that cycle. It shows on `grant_vec` and `grant_word` in the following cycle.
- R4: The store may be empty while a processor is eligible and a push is accepted. The pushed word then skips the store and appears on `grant_word` in the next cycle.
- R5: Grants go to eligible processors in round-robin order. The search starts at the index one above the processor granted last (index 0 after reset) and wraps around.
- R6: At most one push is accepted per cycle. The lowest-index processor with `fork_valid` high wins. An I/O return in store mode (`io_direct` = 0) is accepted only when no processor offers a word.
- R7: The store holds 16 words. When it is full and no word leaves it that cycle, `fork_ready` and store-mode `io_ready` stay low. A push that arrives while the head is being delivered is accepted.
- R8: An I/O return with `io_direct` = 1 is delivered to an eligible processor ahead of any stored word, and the store head stays in place. When no processor is eligible, `io_ready` is low and the word is not taken.
- R9: `grant_prog` equals bits 63..59 of `grant_word`.
- R10: `active_cnt` equals the processor count minus the number of eligible processors.
- R11: `grant_vec` has at most one bit set. It only names a processor whose `wait_req` was high in the cycle before. It never names the same processor in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_req | input | 4 | Per processor: halted after a non-final join, wants a word; dropped after its grant is seen |
| fork_valid | input | 4 | Per processor: offers a forked state word |
| fork_word | input | 256 | Offered words, processor i in bits 64*i+63..64*i |
| fork_ready | output | 4 | Per processor: offered word accepted this cycle |
| io_valid | input | 1 | I/O port returns a state word |
| io_direct | input | 1 | 1: hand straight to a halted processor; 0: place in the store |
| io_word | input | 64 | Returned state word |
| io_ready | output | 1 | Returned word accepted this cycle |
| grant_vec | output | 4 | One-hot: the processor that receives `grant_word` this cycle |
| grant_word | output | 64 | Delivered state word |
| grant_prog | output | 5 | Program number field of the delivered word |
| active_cnt | output | 3 | Number of processors that are running or have a grant pending |

## Verification
Delivery of the store head and acceptance of a new push can happen in the same cycle. The sharpest case is a full store with a halted processor and a fork offer at once. The bench fills the store to 16 words, then raises a wait and a fork together. The reference model expects the head word to be granted, the push to be accepted, and the level to stay at 16. The bench also raises a direct I/O return together with a non-empty store, and expects the I/O word to win while the head stays in place. Random traffic then overlaps pushes, waits and I/O returns, and the model is compared on every clock.

// File: rtl/swd_pkg.sv
package swd_pkg;
  // where the word granted in a cycle comes from
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_IO     = 2'd1,
    SRC_HEAD   = 2'd2,
    SRC_BYPASS = 2'd3
  } swd_src_e;
endpackage

// File: rtl/swd_fifo.sv
module swd_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (wr_en) wp <= step_ptr(wp);
      if (rd_en) rp <= step_ptr(rp);
      case ({wr_en, rd_en})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rd_data = mem[rp];
endmodule

// File: rtl/swd_rr_pick.sv
module swd_rr_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] pick_oh,
  output logic         pick_any
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  int            sel;

  always_comb begin
    sel = -1;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (sel < 0 && req[idx]) sel = idx;
    end
    pick_oh  = '0;
    pick_any = (sel >= 0);
    if (sel >= 0) pick_oh[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (advance && sel >= 0) begin
      ptr <= (sel == N-1) ? '0 : PW'(sel + 1);
    end
  end
endmodule

// File: rtl/swd_dispatch.sv
module swd_dispatch
  import swd_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int WORD_W = 64,
  parameter int DEPTH  = 16,
  parameter int PROG_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_PROC-1:0]             wait_req,
  input  logic [N_PROC-1:0]             fork_valid,
  input  logic [N_PROC*WORD_W-1:0]      fork_word,
  output logic [N_PROC-1:0]             fork_ready,
  input  logic                          io_valid,
  input  logic                          io_direct,
  input  logic [WORD_W-1:0]             io_word,
  output logic                          io_ready,
  output logic [N_PROC-1:0]             grant_vec,
  output logic [WORD_W-1:0]             grant_word,
  output logic [PROG_W-1:0]             grant_prog,
  output logic [$clog2(N_PROC+1)-1:0]   active_cnt
);
  localparam int CNT_W = $clog2(N_PROC+1);
  localparam int LVL_W = $clog2(DEPTH+1);

  // program number lives in the top bits of the word
  function automatic logic [PROG_W-1:0] prog_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: PROG_W];
  endfunction

  // processors counted as running: all except those still eligible
  function automatic logic [CNT_W-1:0] running(input logic [N_PROC-1:0] elig);
    logic [CNT_W-1:0] c;
    c = CNT_W'(N_PROC);
    for (int i = 0; i < N_PROC; i++) if (elig[i]) c = c - 1'b1;
    return c;
  endfunction

  // named internal events
  logic [N_PROC-1:0] eligible;
  logic [N_PROC-1:0] pick_oh;
  logic              any_waiter;
  logic              proc_push;
  int                push_idx;
  logic              io_q_push;
  logic              has_push;
  logic [WORD_W-1:0] push_word;
  logic              io_take_direct;
  swd_src_e          src;
  logic              grant_fire;
  logic              q_pop;
  logic              q_push;
  logic              push_acc;
  logic [WORD_W-1:0] q_head;
  logic [LVL_W-1:0]  q_level;
  logic              q_empty, q_full;
  logic [WORD_W-1:0] next_word;

  assign eligible = wait_req & ~grant_vec;

  swd_rr_pick #(.N(N_PROC)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (eligible),
    .advance  (grant_fire),
    .pick_oh  (pick_oh),
    .pick_any (any_waiter)
  );

  // fixed priority among forking processors, lowest index first
  always_comb begin
    proc_push = 1'b0;
    push_idx  = 0;
    for (int i = N_PROC-1; i >= 0; i--) begin
      if (fork_valid[i]) begin
        proc_push = 1'b1;
        push_idx  = i;
      end
    end
  end

  assign io_q_push = io_valid && !io_direct && !proc_push;
  assign has_push  = proc_push || io_q_push;
  assign push_word = proc_push ? fork_word[push_idx*WORD_W +: WORD_W] : io_word;

  assign q_empty        = (q_level == '0);
  assign q_full         = (q_level == LVL_W'(DEPTH));
  assign io_take_direct = io_valid && io_direct && any_waiter;

  always_comb begin
    if (io_take_direct)             src = SRC_IO;
    else if (any_waiter && !q_empty) src = SRC_HEAD;
    else if (any_waiter && has_push) src = SRC_BYPASS;
    else                             src = SRC_NONE;
  end

  assign grant_fire = (src != SRC_NONE);
  assign q_pop      = (src == SRC_HEAD);
  assign push_acc   = has_push && (!q_full || q_pop);
  assign q_push     = push_acc && (src != SRC_BYPASS);

  always_comb begin
    for (int i = 0; i < N_PROC; i++)
      fork_ready[i] = push_acc && proc_push && (push_idx == i);
  end

  assign io_ready = io_direct ? any_waiter : (io_q_push && push_acc);

  always_comb begin
    case (src)
      SRC_IO:     next_word = io_word;
      SRC_HEAD:   next_word = q_head;
      SRC_BYPASS: next_word = push_word;
      default:    next_word = grant_word;
    endcase
  end

  swd_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (q_push),
    .wr_data (push_word),
    .rd_en   (q_pop),
    .rd_data (q_head),
    .level   (q_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_vec  <= '0;
      grant_word <= '0;
    end else begin
      grant_vec  <= grant_fire ? pick_oh : '0;
      grant_word <= next_word;
    end
  end

  assign grant_prog = prog_of(grant_word);
  assign active_cnt = running(eligible);
endmodule

// File: rtl/swd_chk.sv
module swd_chk #(
  parameter int N_PROC = 4,
  parameter int DEPTH  = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_PROC-1:0]           wait_req,
  input logic [N_PROC-1:0]           grant_vec,
  input logic                        any_waiter,
  input logic                        grant_fire,
  input logic                        q_pop,
  input logic [$clog2(DEPTH+1)-1:0]  q_level,
  input logic [N_PROC-1:0]           fork_ready,
  input logic                        io_ready,
  input logic                        io_direct
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec)); // R11

  AST_GRANT_HAS_WAITER: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != '0) |-> ((grant_vec & $past(wait_req)) == grant_vec)); // R11

  AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != '0) |=> ((grant_vec & $past(grant_vec)) == '0)); // R11

  AST_SERVE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (any_waiter && q_level != '0) |-> grant_fire); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= ($clog2(DEPTH+1))'(DEPTH)); // R7

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_level == ($clog2(DEPTH+1))'(DEPTH) && !q_pop) |-> (fork_ready == '0 && !(io_ready && !io_direct))); // R7

  AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_ready && !io_direct, fork_ready})); // R6
endmodule

bind swd_dispatch swd_chk #(.N_PROC(N_PROC), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wait_req   (wait_req),
  .grant_vec  (grant_vec),
  .any_waiter (any_waiter),
  .grant_fire (grant_fire),
  .q_pop      (q_pop),
  .q_level    (q_level),
  .fork_ready (fork_ready),
  .io_ready   (io_ready),
  .io_direct  (io_direct)
);

// File: tb/tb_swd_dispatch.sv
`timescale 1ns/1ps
module tb_swd_dispatch;
  localparam int N = 4;
  localparam int W = 64;
  localparam int D = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  wr = '0;
  logic [N-1:0]  pv = '0;
  logic [W-1:0]  pw [N];
  logic [N*W-1:0] pw_flat;
  logic          iov = 1'b0, iod = 1'b0;
  logic [W-1:0]  iow = '0;
  logic [N-1:0]  fork_ready, grant_vec;
  logic          io_ready;
  logic [W-1:0]  grant_word;
  logic [4:0]    grant_prog;
  logic [2:0]    active_cnt;

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) pw_flat[i*W +: W] = pw[i];

  swd_dispatch dut (
    .clk(clk), .rst_n(rst_n), .wait_req(wr), .fork_valid(pv), .fork_word(pw_flat),
    .fork_ready(fork_ready), .io_valid(iov), .io_direct(iod), .io_word(iow),
    .io_ready(io_ready), .grant_vec(grant_vec), .grant_word(grant_word),
    .grant_prog(grant_prog), .active_cnt(active_cnt)
  );

  // reference model state
  logic [W-1:0] mq [$];
  int           m_ptr = 0;
  logic [N-1:0] m_gv = '0;
  logic [W-1:0] m_gw = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: entered at a falling edge with inputs already set
  task automatic cyc();
    logic [N-1:0] elig, e_fr;
    int pick, win, src, sz;
    logic acc, pop, byp, e_ior;
    logic [W-1:0] pwd, gw;
    #1;
    elig = wr & ~m_gv;
    pick = -1;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (m_ptr + k) % N;
      if (pick < 0 && elig[idx]) pick = idx;
    end
    win = -1;
    for (int i = N-1; i >= 0; i--) if (pv[i]) win = i;
    if (win < 0 && iov && !iod) win = N;
    pwd = (win == N) ? iow : ((win >= 0) ? pw[win] : '0);
    sz = mq.size();
    src = 0;
    if (iov && iod && pick >= 0) src = 1;
    else if (pick >= 0 && sz > 0) src = 2;
    else if (pick >= 0 && win >= 0) src = 3;
    pop = (src == 2);
    byp = (src == 3);
    acc = (win >= 0) && (sz < D || pop);
    e_fr = '0;
    if (acc && win >= 0 && win < N) e_fr[win] = 1'b1;
    e_ior = iod ? (pick >= 0) : (acc && win == N);
    chk((sz == D) ? "R7 fork_ready" : "R6 fork_ready", W'(fork_ready), W'(e_fr));
    chk("R8 io_ready", W'(io_ready), W'(e_ior));
    chk("R10 active_cnt", W'(active_cnt), W'(N - $countones(elig)));
    gw = m_gw;
    if (src == 1) gw = iow;
    if (src == 2) gw = mq.pop_front();
    if (src == 3) gw = pwd;
    if (acc && !byp) mq.push_back(pwd);
    m_gv = '0;
    if (src != 0) begin
      m_gv[pick] = 1'b1;
      m_ptr = (pick + 1) % N;
    end
    m_gw = gw;
    @(posedge clk);
    #1;
    chk("R5 grant_vec", W'(grant_vec), W'(m_gv));
    chk("R2 grant_word", grant_word, m_gw);
    chk("R9 grant_prog", W'(grant_prog), W'(m_gw[63:59]));
    chk("R11 grant onehot", W'($onehot0(grant_vec)), W'(1'b1));
    wr = wr & ~m_gv;
    @(negedge clk);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) pw[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: state after reset
    cyc();
    chk("R1 grant_vec", W'(grant_vec), '0);
    chk("R1 fork_ready", W'(fork_ready), '0);
    chk("R1 active_cnt", W'(active_cnt), W'(N));

    // R4: empty store, waiters, push in same cycle
    wr = 4'b1110; pv = 4'b0001; pw[0] = 64'hA800_0000_0000_00A1;
    cyc();
    chk("R4 bypass grant", W'(grant_vec), W'(4'b0010));
    chk("R4 bypass word", grant_word, 64'hA800_0000_0000_00A1);
    pv = '0;
    // drain the two remaining waiters with no words: nothing granted
    wr = '0;
    cyc();

    // R6/R7: fill, with competing pushers at first
    for (int k = 0; k < 18; k++) begin
      pv = (k < 3) ? 4'b1010 : 4'b1000;
      pw[1] = {5'(k), 59'(k + 1000)};
      pw[3] = {5'(k + 7), 59'(k + 2000)};
      cyc();
    end
    pv = 4'b0001; pw[0] = 64'h1234;
    cyc();
    chk("R7 full stall", W'(fork_ready), '0);

    // R3 + R7: full store, waiter and push together
    wr = 4'b0100; pv = 4'b0001; pw[0] = 64'hF000_0000_0000_0F0F;
    cyc();
    chk("R3 grant on waiter", W'(grant_vec), W'(4'b0100));
    pv = '0;

    // R5: every processor waits, round robin drains
    wr = 4'b1111;
    repeat (6) cyc();
    wr = 4'b1011;
    repeat (4) cyc();

    // R8: direct I/O return
    wr = '0; iov = 1'b1; iod = 1'b1; iow = 64'h5555_0000_0000_0001;
    cyc();
    chk("R8 direct no waiter", W'(io_ready), '0);
    wr = 4'b0001;
    cyc();
    chk("R8 direct beats head", grant_word, 64'h5555_0000_0000_0001);
    iod = 1'b0; iow = 64'h3333_0000_0000_0002; pv = 4'b0001; pw[0] = 64'h77;
    cyc();
    pv = '0;
    cyc();
    iov = 1'b0;

    // mixed random traffic
    for (int c = 0; c < 500; c++) begin
      wr  = wr | N'($urandom & $urandom & $urandom);
      pv  = N'($urandom & $urandom);
      for (int i = 0; i < N; i++) pw[i] = {$urandom, $urandom};
      iov = (($urandom % 6) == 0);
      iod = $urandom % 2;
      iow = {$urandom, $urandom};
      cyc();
    end
    pv = '0; iov = 1'b0;
    for (int c = 0; c < 40; c++) begin
      wr = 4'b1111;
      cyc();
    end
    chk("R2 store drained", W'(mq.size()), '0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule